// File: doc/BRIEF.md
# Pipeline hazard and branch control

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) deals with data and control hazards. It reads register numbers and a few control bits from the pipeline latches. From them it produces the operand-source selects for the execute stage, a hold for the program counter and the fetch/decode latch with a matching bubble into execute, and a squash-and-redirect pair for fetch when a branch resolves.

Conditional branches compare their operands in the execute stage, and the datapath hands the result to this block. Fetch always assumes a branch is taken. One architectural delay slot follows every branch and always completes. A branch that turns out taken therefore costs nothing. A branch that turns out not taken squashes the single target-path instruction sitting in fetch and sends fetch to the fall-through address. The block is purely combinational in its decisions. The clock and reset only sample the bound property checks.

Top module: `hazard_ctl`

## Requirements
- R1: When the memory-stage instruction writes a nonzero register equal to an execute-stage source, that operand's select is 2'b10 (take the memory-stage result), so a dependent ALU instruction issues back to back with no hold.
- R2: When only the write-back-stage instruction writes a nonzero register equal to an execute-stage source, that operand's select is 2'b01 (take the write-back result).
- R3: When both later stages write the same matching register, the memory-stage result wins (select 2'b10). The value 2'b11 never appears.
- R4: Register zero is never forwarded: a source of 0 yields select 2'b00 (register file) whatever the later stages write.
- R5: If the execute-stage instruction is a load whose destination is nonzero and equals either decode-stage source, `hold_front` and `idex_bubble` are both 1.
- R6: No hold or bubble is raised when the execute-stage instruction is not a load, when the load destination is register zero, or when no decode-stage source matches.
- R7: A branch in execute whose condition is false raises `fetch_redirect` and `ifid_flush` in that cycle.
- R8: A branch in execute whose condition is true raises neither `fetch_redirect` nor `ifid_flush`.
- R9: The condition input is ignored when the execute-stage instruction is not a branch: no redirect and no flush.
- R10: A branch resolution never bubbles the delay-slot instruction: `idex_bubble` stays 0 while `fetch_redirect` is 1.
- R11: A branch reading a register loaded by the instruction just ahead is held exactly one cycle. Two cycles after the hold, with the load in write-back, the branch's operand select is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the bound checks |
| rst | input | 1 | Synchronous active-high reset, disables the checks |
| id_rs | input | 5 | First source register of the decode-stage instruction |
| id_rt | input | 5 | Second source register of the decode-stage instruction |
| ex_rs | input | 5 | First source register of the execute-stage instruction |
| ex_rt | input | 5 | Second source register of the execute-stage instruction |
| ex_rd | input | 5 | Destination register of the execute-stage instruction |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_is_branch | input | 1 | Execute-stage instruction is a conditional branch |
| ex_cond_met | input | 1 | Branch comparison result from the execute datapath |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination register of the write-back-stage instruction |
| wb_reg_write | input | 1 | Write-back-stage instruction writes a register |
| fwd_a_sel | output | 2 | First execute operand source: 00 file, 10 memory stage, 01 write-back |
| fwd_b_sel | output | 2 | Second execute operand source, same coding |
| hold_front | output | 1 | Hold the program counter and the fetch/decode latch |
| idex_bubble | output | 1 | Load an all-clear control word into the decode/execute latch |
| ifid_flush | output | 1 | Squash the target-path instruction now in fetch |
| fetch_redirect | output | 1 | Steer fetch to the fall-through address after the delay slot |

## Verification
Every output is a same-cycle function of the latch contents. Each result is due in the cycle its stimulus is applied, with no register between input and output. The bench changes inputs just after a falling edge and samples one time unit later, well before the next rising edge. The load-then-branch sequence spans three consecutive cycles. Its checks are made in the cycle each latch picture holds: the hold in the first cycle, no hold in the second, and the write-back select in the third.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    parameter int ARCH_REGS = 32;
    localparam int REG_W = $clog2(ARCH_REGS);
    localparam int NUM_OPS = 2;

    typedef logic [REG_W-1:0] reg_id_t;

    typedef enum logic [1:0] {
        FWD_REGF = 2'b00,
        FWD_WB   = 2'b01,
        FWD_MEM  = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        reg_id_t rd;
        logic    wr;
    } writer_t;

    // true when a later-stage writer produces a usable value for src
    function automatic logic writer_hits(writer_t w, reg_id_t src);
        return w.wr && (w.rd != '0) && (w.rd == src);
    endfunction

endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hazard_pkg::*;
(
    input  reg_id_t  src,
    input  writer_t  mem_w,
    input  writer_t  wb_w,
    output fwd_sel_e sel
);
    always_comb begin
        sel = FWD_REGF;
        if (writer_hits(wb_w, src))
            sel = FWD_WB;
        if (writer_hits(mem_w, src))
            sel = FWD_MEM;
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hazard_pkg::*;
(
    input  reg_id_t id_rs,
    input  reg_id_t id_rt,
    input  reg_id_t ex_rd,
    input  logic    ex_mem_read,
    output logic    hold,
    output logic    bubble
);
    logic load_dest_live;
    logic src_match;

    always_comb begin
        load_dest_live = ex_mem_read && (ex_rd != '0);
        src_match      = (ex_rd == id_rs) || (ex_rd == id_rt);
        hold           = load_dest_live && src_match;
        bubble         = hold;
    end
endmodule

// File: rtl/hz_branch_ctl.sv
module hz_branch_ctl (
    input  logic ex_is_branch,
    input  logic ex_cond_met,
    output logic squash,
    output logic redirect
);
    logic mispredict;

    always_comb begin
        // fetch assumed taken; only a false condition is a mispredict
        mispredict = ex_is_branch && !ex_cond_met;
        squash     = mispredict;
        redirect   = mispredict;
    end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import hazard_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic [REG_W-1:0] ex_rs,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_mem_read,
    input  logic             ex_is_branch,
    input  logic             ex_cond_met,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_reg_write,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_reg_write,
    output logic [1:0]       fwd_a_sel,
    output logic [1:0]       fwd_b_sel,
    output logic             hold_front,
    output logic             idex_bubble,
    output logic             ifid_flush,
    output logic             fetch_redirect
);
    writer_t  mem_w;
    writer_t  wb_w;
    reg_id_t  ex_src [NUM_OPS];
    fwd_sel_e op_sel [NUM_OPS];

    assign mem_w     = '{rd: mem_rd, wr: mem_reg_write};
    assign wb_w      = '{rd: wb_rd,  wr: wb_reg_write};
    assign ex_src[0] = ex_rs;
    assign ex_src[1] = ex_rt;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hz_fwd_unit u_fwd (
            .src   (ex_src[g]),
            .mem_w (mem_w),
            .wb_w  (wb_w),
            .sel   (op_sel[g])
        );
    end

    assign fwd_a_sel = op_sel[0];
    assign fwd_b_sel = op_sel[1];

    hz_load_use u_lu (
        .id_rs       (id_rs),
        .id_rt       (id_rt),
        .ex_rd       (ex_rd),
        .ex_mem_read (ex_mem_read),
        .hold        (hold_front),
        .bubble      (idex_bubble)
    );

    hz_branch_ctl u_br (
        .ex_is_branch (ex_is_branch),
        .ex_cond_met  (ex_cond_met),
        .squash       (ifid_flush),
        .redirect     (fetch_redirect)
    );
endmodule

// File: rtl/hazard_ctl_checker.sv
module hazard_ctl_checker
    import hazard_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] ex_rs,
    input logic             ex_is_branch,
    input logic             ex_cond_met,
    input logic [1:0]       fwd_a_sel,
    input logic [1:0]       fwd_b_sel,
    input logic             hold_front,
    input logic             idex_bubble,
    input logic             ifid_flush,
    input logic             fetch_redirect
);
    // R3: the unused select code never appears
    assert_sel_code_R3: assert property (@(posedge clk) disable iff (rst)
        (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

    // R4: register zero always reads from the file
    assert_zero_src_R4: assert property (@(posedge clk) disable iff (rst)
        (ex_rs == '0) |-> (fwd_a_sel == 2'b00));

    // R5: a front-end hold always comes with a bubble behind it
    assert_hold_bubble_R5: assert property (@(posedge clk) disable iff (rst)
        hold_front |-> idex_bubble);

    // R7: redirect and squash travel together
    assert_redirect_squash_R7: assert property (@(posedge clk) disable iff (rst)
        fetch_redirect |-> ifid_flush);

    // R8: a correctly predicted branch leaves fetch alone
    assert_taken_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (ex_is_branch && ex_cond_met) |-> !(fetch_redirect || ifid_flush));

    // R10: the delay slot is never bubbled by a branch
    assert_delay_slot_R10: assert property (@(posedge clk) disable iff (rst)
        fetch_redirect |-> !idex_bubble);
endmodule

bind hazard_ctl hazard_ctl_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .ex_rs          (ex_rs),
    .ex_is_branch   (ex_is_branch),
    .ex_cond_met    (ex_cond_met),
    .fwd_a_sel      (fwd_a_sel),
    .fwd_b_sel      (fwd_b_sel),
    .hold_front     (hold_front),
    .idex_bubble    (idex_bubble),
    .ifid_flush     (ifid_flush),
    .fetch_redirect (fetch_redirect)
);

// File: tb/hazard_ctl_bench.sv
module hazard_ctl_bench;
    import hazard_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [REG_W-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
    logic             ex_mem_read, ex_is_branch, ex_cond_met;
    logic             mem_reg_write, wb_reg_write;
    logic [1:0]       fwd_a_sel, fwd_b_sel;
    logic             hold_front, idex_bubble, ifid_flush, fetch_redirect;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_ctl u_hazard_ctl (
        .clk(clk), .rst(rst),
        .id_rs(id_rs), .id_rt(id_rt),
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd),
        .ex_mem_read(ex_mem_read), .ex_is_branch(ex_is_branch),
        .ex_cond_met(ex_cond_met),
        .mem_rd(mem_rd), .mem_reg_write(mem_reg_write),
        .wb_rd(wb_rd), .wb_reg_write(wb_reg_write),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .hold_front(hold_front), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .fetch_redirect(fetch_redirect)
    );

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_latches();
        id_rs = '0; id_rt = '0; ex_rs = '0; ex_rt = '0; ex_rd = '0;
        ex_mem_read = 1'b0; ex_is_branch = 1'b0; ex_cond_met = 1'b0;
        mem_rd = '0; mem_reg_write = 1'b0; wb_rd = '0; wb_reg_write = 1'b0;
    endtask

    // move to a point between edges before changing inputs
    task automatic next_slot();
        @(negedge clk);
        clear_latches();
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        clear_latches();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        settle();
        chk("R4 reset fwd_a", {2'b0, fwd_a_sel}, 4'h0);
        chk("R4 reset fwd_b", {2'b0, fwd_b_sel}, 4'h0);
        chk("R6 reset hold", {3'b0, hold_front}, 4'h0);
        chk("R9 reset redirect", {2'b0, fetch_redirect, ifid_flush}, 4'h0);
        rst = 1'b0;
    endtask

    task automatic t_fwd_mem();
        next_slot();
        ex_rs = 5'd3; ex_rt = 5'd4; mem_rd = 5'd3; mem_reg_write = 1'b1;
        settle();
        chk("R1 fwd_a from mem", {2'b0, fwd_a_sel}, 4'h2);
        chk("R1 fwd_b untouched", {2'b0, fwd_b_sel}, 4'h0);
        chk("R1 no hold back-to-back", {3'b0, hold_front}, 4'h0);
        next_slot();
        ex_rt = 5'd3; mem_rd = 5'd3; mem_reg_write = 1'b0;
        settle();
        chk("R1 no write no fwd", {2'b0, fwd_b_sel}, 4'h0);
    endtask

    task automatic t_fwd_wb();
        next_slot();
        ex_rt = 5'd7; wb_rd = 5'd7; wb_reg_write = 1'b1; mem_rd = 5'd7;
        settle();
        chk("R2 fwd_b from wb", {2'b0, fwd_b_sel}, 4'h1);
        chk("R2 fwd_a untouched", {2'b0, fwd_a_sel}, 4'h0);
    endtask

    task automatic t_priority();
        next_slot();
        ex_rs = 5'd9; ex_rt = 5'd9;
        mem_rd = 5'd9; mem_reg_write = 1'b1;
        wb_rd = 5'd9; wb_reg_write = 1'b1;
        settle();
        chk("R3 mem wins a", {2'b0, fwd_a_sel}, 4'h2);
        chk("R3 mem wins b", {2'b0, fwd_b_sel}, 4'h2);
    endtask

    task automatic t_zero();
        next_slot();
        mem_reg_write = 1'b1; wb_reg_write = 1'b1;
        settle();
        chk("R4 zero a", {2'b0, fwd_a_sel}, 4'h0);
        chk("R4 zero b", {2'b0, fwd_b_sel}, 4'h0);
    endtask

    task automatic t_load_use();
        next_slot();
        ex_mem_read = 1'b1; ex_rd = 5'd2; id_rt = 5'd2; id_rs = 5'd6;
        settle();
        chk("R5 rt match hold", {2'b0, hold_front, idex_bubble}, 4'h3);
        next_slot();
        ex_mem_read = 1'b1; ex_rd = 5'd2; id_rs = 5'd2;
        settle();
        chk("R5 rs match hold", {2'b0, hold_front, idex_bubble}, 4'h3);
        next_slot();
        ex_rd = 5'd2; id_rs = 5'd2;
        settle();
        chk("R6 not a load", {2'b0, hold_front, idex_bubble}, 4'h0);
        next_slot();
        ex_mem_read = 1'b1;
        settle();
        chk("R6 load to r0", {2'b0, hold_front, idex_bubble}, 4'h0);
        next_slot();
        ex_mem_read = 1'b1; ex_rd = 5'd8; id_rs = 5'd1; id_rt = 5'd2;
        settle();
        chk("R6 no source match", {2'b0, hold_front, idex_bubble}, 4'h0);
    endtask

    task automatic t_branch();
        next_slot();
        ex_is_branch = 1'b1; ex_cond_met = 1'b0;
        settle();
        chk("R7 not taken redirect+flush", {2'b0, fetch_redirect, ifid_flush}, 4'h3);
        chk("R10 delay slot kept", {3'b0, idex_bubble}, 4'h0);
        next_slot();
        ex_is_branch = 1'b1; ex_cond_met = 1'b1;
        settle();
        chk("R8 taken quiet", {2'b0, fetch_redirect, ifid_flush}, 4'h0);
        next_slot();
        ex_cond_met = 1'b0;
        settle();
        chk("R9 non-branch low cond", {2'b0, fetch_redirect, ifid_flush}, 4'h0);
        next_slot();
        ex_cond_met = 1'b1;
        settle();
        chk("R9 non-branch high cond", {2'b0, fetch_redirect, ifid_flush}, 4'h0);
    endtask

    task automatic t_load_then_branch();
        // cycle 1: load in EX writes r2, branch in ID reads r2
        next_slot();
        ex_mem_read = 1'b1; ex_rd = 5'd2; id_rs = 5'd2;
        settle();
        chk("R11 first cycle held", {3'b0, hold_front}, 4'h1);
        // cycle 2: bubble in EX, load in MEM, branch still in ID
        next_slot();
        mem_rd = 5'd2; mem_reg_write = 1'b1; id_rs = 5'd2;
        settle();
        chk("R11 second cycle released", {3'b0, hold_front}, 4'h0);
        // cycle 3: branch in EX, load in WB
        next_slot();
        ex_rs = 5'd2; ex_is_branch = 1'b1; ex_cond_met = 1'b1;
        wb_rd = 5'd2; wb_reg_write = 1'b1;
        settle();
        chk("R11 branch takes wb value", {2'b0, fwd_a_sel}, 4'h1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_fwd_mem();
        t_fwd_wb();
        t_priority();
        t_zero();
        t_load_use();
        t_branch();
        t_load_then_branch();
        next_slot();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule